// File: doc/BRIEF.md
# Processor status flag register

This block holds the 8-bit status byte of a small 8-bit processor and produces the ALU result and flags that feed it. Each cycle it receives two operand bytes, an operation code and an execute strobe. When the strobe is high, the flags that the operation affects are updated at the next clock edge. A destination flag marks the status byte itself as the target of the instruction. In that case the ALU result is the data written into the status byte. The register applies the rules for which bits such a write may change.

Four device-event strobes act on the time-out and power-down bits: power-on, watchdog clear, sleep entry and watchdog timeout. Instructions never change these two bits. The bank-select bit is driven out to pick the data-memory bank for direct addressing. The two reserved upper bits always read zero.

Status bit layout, MSB to LSB: bit 7 reserved, bit 6 reserved, bit 5 bank select, bit 4 time-out, bit 3 power-down, bit 2 zero (Z), bit 1 digit carry (DC), bit 0 carry (C).

Operation codes on `op_sel_i`:

| Code | Operation | Flags affected |
|------|-----------|----------------|
| 0 | add | Z, DC, C |
| 1 | subtract (a − b) | Z, DC, C |
| 2 | AND | Z |
| 3 | OR | Z |
| 4 | XOR | Z |
| 5 | rotate left through carry | C |
| 6 | rotate right through carry | C |
| 7 | clear | Z |
| 8 | move (result = a) | none |
| 9 | nibble swap of a | none |
| 10–15 | behave as move | none |

Top module: `cpu_flag_reg`

## Requirements
- R1: After the asynchronous reset, and one cycle after a `por_i` strobe, `status_o` is 8'h18: bank 0, time-out 1, power-down 1, and Z, DC and C all 0. `por_i` overrides every other input in the same cycle.
- R2: Bits 7 and 6 of `status_o` are 0 at all times.
- R3: When `exec_i` and `dst_stat_i` are both high, bit 5 (bank select) takes bit 5 of the result. Otherwise bit 5 keeps its value. `bank_sel_o` always equals bit 5.
- R4: A watchdog timeout clears time-out (bit 4). A watchdog clear sets time-out and power-down (bit 3). Sleep entry sets time-out and clears power-down. When a timeout and a clear arrive in the same cycle, time-out becomes 0 and power-down becomes 1. When sleep and a clear arrive together, time-out becomes 1 and power-down becomes 0.
- R5: Bits 4 and 3 change only through the event strobes. An instruction write to the status byte never changes them.
- R6: Add (code 0): `result_o` = (a+b) mod 256. C is the carry out of bit 7, DC is the carry out of bit 3, and Z is 1 exactly when the 8-bit result is 0.
- R7: Subtract (code 1): `result_o` = (a−b) mod 256. C = 1 when a ≥ b and DC = 1 when a[3:0] ≥ b[3:0], so both flags are inverted borrows. Z is set as in R6.
- R8: AND, OR and XOR (codes 2, 3, 4) and clear (code 7, result 0) update only Z. DC and C keep their values.
- R9: Rotate left (code 5) gives result {a[6:0], C} and loads C from a[7]. Rotate right (code 6) gives result {C, a[7:1]} and loads C from a[0]. Z and DC keep their values. `result_o` uses the C held before the edge.
- R10: When the status byte is the destination of an operation that affects any of Z, DC or C, the data write to those three bits is ignored. Affected flags take their computed values and the others keep their values. Clear to the status byte therefore gives the pattern 000u u1uu.
- R11: Move, swap and codes 10–15 affect no flags. With `dst_stat_i` high, Z, DC and C take result bits 2, 1 and 0. With `dst_stat_i` low, the status byte is unchanged.
- R12: While `exec_i` is low, bits 5, 2, 1 and 0 keep their values whatever the operands, operation code and destination flag are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a_i | input | 8 | First operand, also the rotate, move and swap source |
| op_b_i | input | 8 | Second operand |
| op_sel_i | input | 4 | Operation code |
| exec_i | input | 1 | Instruction executes this cycle |
| dst_stat_i | input | 1 | The result is written to the status byte |
| por_i | input | 1 | Power-on event strobe |
| wdt_clr_i | input | 1 | Watchdog clear event strobe |
| sleep_i | input | 1 | Sleep entry event strobe |
| wdt_to_i | input | 1 | Watchdog timeout event strobe |
| status_o | output | 8 | Status byte |
| result_o | output | 8 | Combinational ALU result |
| bank_sel_o | output | 1 | Data bank select for direct addressing |

## Verification
A wrong flag value is visible on `status_o` one clock after the instruction that should have set it. It also feeds straight back into `result_o` through the carry on the next rotate, in the same cycle that rotate is presented. A write-suppression fault shows up as Z, DC or C taking result bits in place of computed or held values after a status-destination instruction. An event fault shows up as a wrong time-out or power-down bit one cycle after the strobe. Sweeps over every operand value for each operation, followed by a long random mix, expose such faults within a few cycles of the triggering instruction.

// File: rtl/cpu_flag_pkg.sv
package cpu_flag_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_IOR  = 4'd3,
    OP_XOR  = 4'd4,
    OP_RLC  = 4'd5,
    OP_RRC  = 4'd6,
    OP_CLR  = 4'd7,
    OP_MOV  = 4'd8,
    OP_SWAP = 4'd9
  } alu_op_e;

  // status byte bit positions
  localparam int unsigned ST_C   = 0;
  localparam int unsigned ST_DC  = 1;
  localparam int unsigned ST_Z   = 2;
  localparam int unsigned ST_PD  = 3;
  localparam int unsigned ST_TO  = 4;
  localparam int unsigned ST_RP0 = 5;
  localparam int unsigned ST_RP1 = 6;
  localparam int unsigned ST_IRP = 7;

  localparam int unsigned NFLAG = 3;
  localparam logic [7:0] ST_RESET = 8'h18;

  typedef struct packed {
    logic z;
    logic dc;
    logic c;
  } flag_t;

endpackage

// File: rtl/flag_alu.sv
module flag_alu
  import cpu_flag_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  alu_op_e       op_i,
  input  logic          c_in_i,
  output logic [DW-1:0] res_o,
  output flag_t         calc_o,
  output flag_t         aff_o
);

  localparam int NIB = DW / 2;

  logic [DW:0]   wide;
  logic [NIB:0]  half;
  logic [DW-1:0] b_eff;
  logic          cin;

  always_comb begin
    b_eff  = b_i;
    cin    = 1'b0;
    wide   = '0;
    half   = '0;
    res_o  = a_i;
    calc_o = '0;
    aff_o  = '0;
    case (op_i)
      OP_ADD, OP_SUB: begin
        if (op_i == OP_SUB) begin
          b_eff = ~b_i;
          cin   = 1'b1;
        end
        wide = {1'b0, a_i} + {1'b0, b_eff} + {{DW{1'b0}}, cin};
        half = {1'b0, a_i[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, cin};
        res_o     = wide[DW-1:0];
        calc_o.c  = wide[DW];
        calc_o.dc = half[NIB];
        aff_o     = '1;
      end
      OP_AND: begin res_o = a_i & b_i; aff_o.z = 1'b1; end
      OP_IOR: begin res_o = a_i | b_i; aff_o.z = 1'b1; end
      OP_XOR: begin res_o = a_i ^ b_i; aff_o.z = 1'b1; end
      OP_RLC: begin
        res_o    = {a_i[DW-2:0], c_in_i};
        calc_o.c = a_i[DW-1];
        aff_o.c  = 1'b1;
      end
      OP_RRC: begin
        res_o    = {c_in_i, a_i[DW-1:1]};
        calc_o.c = a_i[0];
        aff_o.c  = 1'b1;
      end
      OP_CLR:  begin res_o = '0; aff_o.z = 1'b1; end
      OP_SWAP: res_o = {a_i[NIB-1:0], a_i[DW-1:NIB]};
      default: res_o = a_i;
    endcase
    calc_o.z = (res_o == '0);
  end

endmodule

// File: rtl/flag_merge.sv
module flag_merge
  import cpu_flag_pkg::*;
(
  input  logic  exec_i,
  input  logic  dst_i,
  input  flag_t wr_flags_i,
  input  logic  wr_rp0_i,
  input  flag_t calc_i,
  input  flag_t aff_i,
  input  flag_t cur_i,
  input  logic  rp0_q_i,
  output flag_t flg_d_o,
  output logic  rp0_d_o
);

  logic [NFLAG-1:0] wr_v, calc_v, aff_v, cur_v, nxt_v;
  logic             any_aff;
  logic             direct_wr;

  assign wr_v      = wr_flags_i;
  assign calc_v    = calc_i;
  assign aff_v     = aff_i;
  assign cur_v     = cur_i;
  assign any_aff   = |aff_v;
  // data write reaches the flags only when the instruction touches none of them
  assign direct_wr = exec_i & dst_i & ~any_aff;

  for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag
    assign nxt_v[gi] = direct_wr                ? wr_v[gi]   :
                       (exec_i & aff_v[gi])     ? calc_v[gi] :
                                                  cur_v[gi];
  end

  assign flg_d_o = flag_t'(nxt_v);
  assign rp0_d_o = (exec_i & dst_i) ? wr_rp0_i : rp0_q_i;

endmodule

// File: rtl/flag_event_ctl.sv
module flag_event_ctl (
  input  logic to_q_i,
  input  logic pd_q_i,
  input  logic wdt_clr_i,
  input  logic sleep_i,
  input  logic wdt_to_i,
  output logic to_d_o,
  output logic pd_d_o
);

  always_comb begin
    to_d_o = to_q_i;
    if (wdt_to_i)                 to_d_o = 1'b0;
    else if (wdt_clr_i | sleep_i) to_d_o = 1'b1;

    pd_d_o = pd_q_i;
    if (sleep_i)        pd_d_o = 1'b0;
    else if (wdt_clr_i) pd_d_o = 1'b1;
  end

endmodule

// File: rtl/cpu_flag_reg.sv
module cpu_flag_reg
  import cpu_flag_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] op_a_i,
  input  logic [DW-1:0] op_b_i,
  input  logic [3:0]    op_sel_i,
  input  logic          exec_i,
  input  logic          dst_stat_i,
  input  logic          por_i,
  input  logic          wdt_clr_i,
  input  logic          sleep_i,
  input  logic          wdt_to_i,
  output logic [7:0]    status_o,
  output logic [DW-1:0] result_o,
  output logic          bank_sel_o
);

  logic [7:0]    st_q, st_d;
  logic          upd;
  logic [DW-1:0] res;
  flag_t         calc, aff, cur, flg_d, wr_flags;
  logic          rp0_d, to_d, pd_d;

  assign cur      = flag_t'({st_q[ST_Z], st_q[ST_DC], st_q[ST_C]});
  assign wr_flags = flag_t'({res[ST_Z], res[ST_DC], res[ST_C]});

  flag_alu #(.DW(DW)) u_alu (
    .a_i    (op_a_i),
    .b_i    (op_b_i),
    .op_i   (alu_op_e'(op_sel_i)),
    .c_in_i (st_q[ST_C]),
    .res_o  (res),
    .calc_o (calc),
    .aff_o  (aff)
  );

  flag_merge u_merge (
    .exec_i     (exec_i),
    .dst_i      (dst_stat_i),
    .wr_flags_i (wr_flags),
    .wr_rp0_i   (res[ST_RP0]),
    .calc_i     (calc),
    .aff_i      (aff),
    .cur_i      (cur),
    .rp0_q_i    (st_q[ST_RP0]),
    .flg_d_o    (flg_d),
    .rp0_d_o    (rp0_d)
  );

  flag_event_ctl u_evt (
    .to_q_i    (st_q[ST_TO]),
    .pd_q_i    (st_q[ST_PD]),
    .wdt_clr_i (wdt_clr_i),
    .sleep_i   (sleep_i),
    .wdt_to_i  (wdt_to_i),
    .to_d_o    (to_d),
    .pd_d_o    (pd_d)
  );

  // next-state
  always_comb begin
    upd          = por_i | exec_i | wdt_clr_i | sleep_i | wdt_to_i;
    st_d         = st_q;
    st_d[ST_IRP] = 1'b0;
    st_d[ST_RP1] = 1'b0;
    st_d[ST_RP0] = rp0_d;
    st_d[ST_TO]  = to_d;
    st_d[ST_PD]  = pd_d;
    st_d[ST_Z]   = flg_d.z;
    st_d[ST_DC]  = flg_d.dc;
    st_d[ST_C]   = flg_d.c;
    if (por_i) st_d = ST_RESET;
  end

  // register with clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   st_q <= ST_RESET;
    else if (upd) st_q <= st_d;
  end

  assign status_o   = st_q;
  assign result_o   = res;
  assign bank_sel_o = st_q[ST_RP0];

endmodule

// File: rtl/cpu_flag_reg_chk.sv
module cpu_flag_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] op_a_i,
  input logic [7:0] op_b_i,
  input logic [3:0] op_sel_i,
  input logic       exec_i,
  input logic       dst_stat_i,
  input logic       por_i,
  input logic       wdt_clr_i,
  input logic       sleep_i,
  input logic       wdt_to_i,
  input logic [7:0] status_o,
  input logic [7:0] result_o
);

  // R1
  por_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    por_i |=> status_o == 8'h18);

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[7:6] == 2'b00);

  // R3
  bank_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && dst_stat_i && !por_i) |=> status_o[5] == $past(result_o[5]));

  // R4
  timeout_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_to_i && !por_i) |=> !status_o[4]);

  // R4
  sleep_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_i && !por_i) |=> !status_o[3]);

  // R5
  topd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(por_i || wdt_to_i || wdt_clr_i || sleep_i) |=> $stable(status_o[4:3]));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!por_i && !exec_i) |=> ($stable(status_o[2:0]) && $stable(status_o[5])));

  // R10
  clr_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && dst_stat_i && op_sel_i == 4'd7 && !por_i)
      |=> (status_o[7:5] == 3'b000 && status_o[2] && $stable(status_o[1:0])));

  // R6
  add_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && !dst_stat_i && op_sel_i == 4'd0 && !por_i)
      |=> status_o[0] == $past(({1'b0, op_a_i} + {1'b0, op_b_i}) >= 9'h100));

endmodule

bind cpu_flag_reg cpu_flag_reg_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_a_i     (op_a_i),
  .op_b_i     (op_b_i),
  .op_sel_i   (op_sel_i),
  .exec_i     (exec_i),
  .dst_stat_i (dst_stat_i),
  .por_i      (por_i),
  .wdt_clr_i  (wdt_clr_i),
  .sleep_i    (sleep_i),
  .wdt_to_i   (wdt_to_i),
  .status_o   (status_o),
  .result_o   (result_o)
);

// File: tb/cpu_flag_reg_test.sv
module cpu_flag_reg_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] op_a, op_b;
  logic [3:0] op_sel;
  logic       exec, dst, por, wclr, slp, wto;
  logic [7:0] status, result;
  logic       bank;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;
  logic [7:0] es;

  always #4 clk = ~clk;

  cpu_flag_reg uut (
    .clk(clk), .rst_n(rst_n), .op_a_i(op_a), .op_b_i(op_b), .op_sel_i(op_sel),
    .exec_i(exec), .dst_stat_i(dst), .por_i(por), .wdt_clr_i(wclr),
    .sleep_i(slp), .wdt_to_i(wto), .status_o(status), .result_o(result),
    .bank_sel_o(bank)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ref_alu(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic cin, output logic [7:0] r,
                         output logic [2:0] fl, output logic [2:0] af);
    int s;
    fl = 3'b000; af = 3'b000; r = a;
    case (op)
      4'd0: begin s = a + b; r = 8'(s); fl[0] = (s > 255);
                  fl[1] = ((a % 16) + (b % 16) > 15); af = 3'b111; end
      4'd1: begin r = 8'(a - b); fl[0] = (a >= b); fl[1] = ((a % 16) >= (b % 16)); af = 3'b111; end
      4'd2: begin r = a & b; af = 3'b100; end
      4'd3: begin r = a | b; af = 3'b100; end
      4'd4: begin r = a ^ b; af = 3'b100; end
      4'd5: begin r = {a[6:0], cin}; fl[0] = a[7]; af = 3'b001; end
      4'd6: begin r = {cin, a[7:1]}; fl[0] = a[0]; af = 3'b001; end
      4'd7: begin r = 8'h00; af = 3'b100; end
      4'd9: r = {a[3:0], a[7:4]};
      default: r = a;
    endcase
    fl[2] = (r == 8'h00);
  endtask

  function automatic string req_of(input logic [3:0] op, input logic d);
    if (d) return "R10/R11";
    case (op)
      4'd0: return "R6";
      4'd1: return "R7";
      4'd2, 4'd3, 4'd4, 4'd7: return "R8";
      4'd5, 4'd6: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic apply(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic ex, input logic d, input logic p,
                       input logic cl, input logic sl, input logic to);
    logic [7:0] r;
    logic [2:0] fl, af;
    op_sel = op; op_a = a; op_b = b; exec = ex; dst = d;
    por = p; wclr = cl; slp = sl; wto = to;
    ref_alu(op, a, b, es[0], r, fl, af);
    #1;
    chk({req_of(op, 1'b0), " result"}, result, r);
    if (p) es = 8'h18;
    else begin
      if (ex) begin
        if (d) es[5] = r[5];
        for (int k = 0; k < 3; k++) begin
          if (d && af == 3'b000) es[k] = r[k];
          else if (af[k])        es[k] = fl[k];
        end
      end
      if (to) es[4] = 1'b0; else if (cl || sl) es[4] = 1'b1;
      if (sl) es[3] = 1'b0; else if (cl) es[3] = 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    if (p)                         chk("R1 status", status, es);
    else if (cl || sl || to)       chk("R4 R5 status", status, es);
    else if (!ex)                  chk("R12 status", status, es);
    else                           chk({req_of(op, d), " R2 R5 status"}, status, es);
    chk("R3 bank", {7'd0, bank}, {7'd0, es[5]});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 190000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] bset [8];
    bset = '{8'h00, 8'h01, 8'h0F, 8'h10, 8'h7F, 8'h80, 8'hF0, 8'hFF};
    rst_n = 1'b0; op_a = 0; op_b = 0; op_sel = 0;
    exec = 0; dst = 0; por = 0; wclr = 0; slp = 0; wto = 0;
    es = 8'h18;
    repeat (3) @(negedge clk);
    chk("R1 reset status", status, 8'h18);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", status, 8'h18);

    // R4 event sequence
    apply(4'd8, 8'h00, 8'h00, 0, 0, 0, 0, 1, 0);  // sleep
    chk("R4 sleep", status, 8'h10);
    apply(4'd8, 8'h00, 8'h00, 0, 0, 0, 0, 0, 1);  // timeout
    chk("R4 timeout", status, 8'h00);
    apply(4'd8, 8'h00, 8'h00, 0, 0, 0, 1, 0, 0);  // clear
    chk("R4 clear", status, 8'h18);
    apply(4'd8, 8'h00, 8'h00, 0, 0, 0, 1, 0, 1);  // timeout + clear
    chk("R4 timeout over clear", status, 8'h08);
    apply(4'd8, 8'h00, 8'h00, 0, 0, 0, 1, 1, 0);  // sleep + clear
    chk("R4 sleep with clear", status, 8'h10);

    // R5: write all ones then zeros to status by move; TO/PD untouched
    apply(4'd8, 8'hFF, 8'h00, 1, 1, 0, 0, 0, 0);
    chk("R5 R2 move ones", status, 8'h37);
    apply(4'd8, 8'h00, 8'h00, 1, 1, 0, 0, 0, 0);
    chk("R5 move zeros", status, 8'h10);

    // R10 clear to status from a state with DC=C=1
    apply(4'd8, 8'h23, 8'h00, 1, 1, 0, 0, 0, 0);
    apply(4'd7, 8'h55, 8'h00, 1, 1, 0, 0, 0, 0);
    chk("R10 clear pattern", status, 8'h17);

    // R1 por strobe mid-run, with an instruction in the same cycle
    apply(4'd0, 8'hFF, 8'h01, 1, 0, 1, 0, 1, 0);
    chk("R1 por strobe", status, 8'h18);

    // R6 R7 sweeps
    for (int op = 0; op < 2; op++)
      for (int a = 0; a < 256; a++)
        for (int j = 0; j < 8; j++)
          apply(4'(op), 8'(a), bset[j], 1, 0, 0, 0, 0, 0);

    // R8 logic ops and clear
    for (int op = 2; op < 5; op++)
      for (int a = 0; a < 256; a++)
        for (int j = 0; j < 4; j++)
          apply(4'(op), 8'(a), bset[j * 2 + (a % 2)], 1, 0, 0, 0, 0, 0);
    for (int a = 0; a < 16; a++) apply(4'd7, 8'(a), 8'h00, 1, 0, 0, 0, 0, 0);

    // R9 rotate chains
    for (int op = 5; op < 7; op++)
      for (int a = 0; a < 256; a++)
        apply(4'(op), 8'(a * 37), 8'h00, 1, 0, 0, 0, 0, 0);

    // R11 move/swap/undefined to and not to status
    for (int a = 0; a < 256; a++) begin
      apply(4'd9, 8'(a), 8'h00, 1, 1, 0, 0, 0, 0);
      apply(4'(8 + (a % 8)), 8'(a ^ 8'h5A), 8'h00, 1, a % 2 == 1, 0, 0, 0, 0);
    end

    // R10 arithmetic and rotate to status: data write suppressed
    for (int a = 0; a < 256; a++) begin
      apply(4'(a % 2), 8'(a), 8'(a * 3), 1, 1, 0, 0, 0, 0);
      apply(4'(5 + (a % 2)), 8'(a), 8'h00, 1, 1, 0, 0, 0, 0);
      apply(4'(2 + (a % 3)), 8'(a), 8'hC3, 1, 1, 0, 0, 0, 0);
    end

    // R12 idle cycles with busy inputs
    for (int a = 0; a < 64; a++)
      apply(4'(a % 16), 8'(a * 5), 8'(a * 11), 0, a % 2 == 0, 0, 0, 0, 0);

    // random mix of everything
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] rv;
      rv = $urandom;
      apply(rv[3:0], rv[11:4], rv[19:12], rv[20] | rv[21], rv[22],
            rv[31:26] == 6'd0, rv[25:23] == 3'd1, rv[25:23] == 3'd2,
            rv[25:23] == 3'd3 || rv[25:23] == 3'd4);
    end

    finish_run();
  end

endmodule